// File: doc/BRIEF.md
# Watchdog Timer with Pre-Timeout NMI

This block is a hardware watchdog on a simple register port. Software programs a 16-bit reload value, counted in 128 ms units, and then sets the run bit in a control register. While it runs, the block decrements the remaining count once per coarse tick. A prescaler makes that tick from the core clock. A non-maskable pre-timeout interrupt warns firmware roughly nine seconds before the count runs out, so that the event can be logged. If the count reaches zero, a system reset output that removes power is asserted.

Software keeps the system alive by writing the reload register again before expiry. That write restarts the countdown from the written value. Clearing the run bit stops the countdown. The reset pulse lasts one tick. After the pulse the block stops by itself and clears its run bit. The other control bits keep their values.

A package holds the conversion from seconds to count units. The reset-default reload value (30 s gives 234 units) and the interrupt threshold (9 s rounded up gives 71 units) are both derived from it.

Top module: `wdt_nmi_top`

## Requirements
- R1: After reset the reload offset (0x70) reads the default count, the control offset (0x72) reads 0, and both the interrupt and reset outputs are low.
- R2: A write to the reload offset stores the value and loads it as the remaining count. Reads of the reload offset return the remaining count. While the run bit (control bit 0) is clear, that count does not change.
- R3: A write to the control offset stores bits 7:0 and ignores bits 15:8, which read as 0. A write that sets bit 0 while it was clear loads the remaining count from the stored reload value.
- R4: While running, the count drops by one every TICK_DIV clocks, and the first drop comes TICK_DIV clocks after the load.
- R5: A reload write while running restarts the countdown from the new value and restarts the tick phase. If the new value is above the threshold, it also drops the interrupt.
- R6: The interrupt is a level that is high whenever the run bit is set and the remaining count is at or below PRE_TICKS (default 71). A load at or below the threshold raises it in the same cycle.
- R7: The tick on which the count reaches 0 asserts the reset output for exactly one tick. Then the reset ends, bit 0 of the control register clears, bits 7:1 are kept, and the interrupt drops.
- R8: Clearing bit 0 holds the count and drops both outputs. Writing bit 0 as 1 while already running does not reload the count.
- R9: A remaining count of 0 expires on the first tick after it is loaded.
- R10: The count unit is 128 ms: seconds convert to units as s*1000/128, truncated (30 s gives 234, 600 s gives 4687). The default reload value is the 30 s conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| pretimeout_nmi | output | 1 | Pre-timeout non-maskable interrupt level |
| sys_reset | output | 1 | Power-removing system reset, one tick long |

## Verification
The bench builds the block with TICK_DIV set to 4 and leaves all other parameters at their defaults. A tick is then four clocks, so a full countdown from 80 units takes about 320 clocks. With that load the bench can step through the threshold crossing at 71, expiry, the one-tick reset pulse and the automatic stop cycle by cycle. The threshold and the 30 s default keep their real values.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned UNIT_MS = 128;

  // whole count units in a number of seconds, rounded down
  function automatic int unsigned secs_to_units(input int unsigned secs);
    return (secs * 1000) / UNIT_MS;
  endfunction

  // count units covering a number of seconds, rounded up
  function automatic int unsigned secs_to_units_ceil(input int unsigned secs);
    return (secs * 1000 + UNIT_MS - 1) / UNIT_MS;
  endfunction
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic clear,
  output logic tick
);
  generate
    if (TICK_DIV == 1) begin : g_direct
      assign tick = run_en && !clear;
    end else begin : g_div
      localparam int unsigned PW = $clog2(TICK_DIV);
      localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);
      logic [PW-1:0] phase_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       phase_q <= '0;
        else if (clear || !run_en)        phase_q <= '0;
        else if (phase_q == LAST)         phase_q <= '0;
        else                              phase_q <= phase_q + 1'b1;
      end

      assign tick = run_en && !clear && (phase_q == LAST);

      assert_phase_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q <= LAST);
      assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs #(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned CNT_W      = 16,
  parameter logic [ADDR_W-1:0] RELOAD_OFS = 'h70,
  parameter logic [ADDR_W-1:0] CTRL_OFS   = 'h72,
  parameter logic [CNT_W-1:0]  RESET_UNITS = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              fire_end,
  output logic              run_en,
  output logic              load,
  output logic [CNT_W-1:0]  load_val
);
  logic [7:0]       ctrl_q;
  logic [CNT_W-1:0] reload_q;
  logic             wr_reload, wr_ctrl, start;

  assign wr_reload = bus_wr && (bus_addr == RELOAD_OFS);
  assign wr_ctrl   = bus_wr && (bus_addr == CTRL_OFS);
  assign start     = wr_ctrl && bus_wdata[0] && !ctrl_q[0];
  assign load      = wr_reload || start;
  assign load_val  = wr_reload ? bus_wdata[CNT_W-1:0] : reload_q;
  assign run_en    = ctrl_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      reload_q <= RESET_UNITS;
    end else begin
      if (wr_reload) reload_q <= bus_wdata[CNT_W-1:0];
      if (wr_ctrl)       ctrl_q    <= bus_wdata[7:0];
      else if (fire_end) ctrl_q[0] <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == RELOAD_OFS)    bus_rdata = 16'(count);
    else if (bus_addr == CTRL_OFS) bus_rdata = {8'h00, ctrl_q};
  end

  assert_expiry_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_end && !wr_ctrl) |=> !run_en);
  assert_expiry_keeps_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_end && !wr_ctrl) |=> (ctrl_q[7:1] == $past(ctrl_q[7:1])));
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int unsigned CNT_W = 16,
  parameter logic [CNT_W-1:0] PRE_TICKS   = 71,
  parameter logic [CNT_W-1:0] RESET_UNITS = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             pretimeout,
  output logic             sys_reset,
  output logic             fire_end
);
  logic [CNT_W-1:0] count_q;
  logic             firing_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= RESET_UNITS;
      firing_q <= 1'b0;
    end else if (load) begin
      count_q  <= load_val;
      firing_q <= 1'b0;
    end else if (!run_en) begin
      firing_q <= 1'b0;
    end else if (tick) begin
      if (firing_q)              firing_q <= 1'b0;
      else if (count_q <= 1) begin
        count_q  <= '0;
        firing_q <= 1'b1;
      end else                   count_q <= count_q - 1'b1;
    end
  end

  assign count      = count_q;
  assign sys_reset  = firing_q;
  assign fire_end   = tick && firing_q && run_en && !load;
  assign pretimeout = run_en && (count_q <= PRE_TICKS);

  assert_step_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && tick && !load && !firing_q && count_q > 1) |=> (count_q == $past(count_q) - 1'b1));
  assert_hold_between_ticks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(count_q));
  assert_reset_one_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fire_end |=> !sys_reset);
  assert_reset_under_nmi_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset |-> pretimeout);
  assert_ping_cancels_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !sys_reset);
  assert_stop_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !sys_reset);
endmodule

// File: rtl/wdt_nmi_top.sv
module wdt_nmi_top #(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned TICK_DIV   = 12_800_000,
  parameter int unsigned DEFAULT_S  = 30,
  parameter int unsigned PRE_S      = 9,
  parameter logic [ADDR_W-1:0] RELOAD_OFS = 'h70,
  parameter logic [ADDR_W-1:0] CTRL_OFS   = 'h72
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              pretimeout_nmi,
  output logic              sys_reset
);
  localparam int unsigned CNT_W = 16;
  localparam logic [CNT_W-1:0] RESET_UNITS = CNT_W'(wdt_pkg::secs_to_units(DEFAULT_S));
  localparam logic [CNT_W-1:0] PRE_TICKS   = CNT_W'(wdt_pkg::secs_to_units_ceil(PRE_S));

  logic             run_en, load, tick, fire_end;
  logic [CNT_W-1:0] load_val, count;

  wdt_regs #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .RELOAD_OFS(RELOAD_OFS),
    .CTRL_OFS(CTRL_OFS), .RESET_UNITS(RESET_UNITS)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .count(count),
    .fire_end(fire_end), .run_en(run_en), .load(load), .load_val(load_val)
  );

  wdt_prescaler #(.TICK_DIV(TICK_DIV)) presc_i (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .clear(load), .tick(tick)
  );

  wdt_countdown #(
    .CNT_W(CNT_W), .PRE_TICKS(PRE_TICKS), .RESET_UNITS(RESET_UNITS)
  ) cnt_i (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .tick(tick), .load(load),
    .load_val(load_val), .count(count), .pretimeout(pretimeout_nmi),
    .sys_reset(sys_reset), .fire_end(fire_end)
  );

  assert_nmi_needs_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pretimeout_nmi |-> run_en);
endmodule

// File: tb/wdt_nmi_top_tb_top.sv
`timescale 1ns/1ps
module wdt_nmi_top_tb_top;
  localparam int unsigned TDIV = 4;
  localparam logic [7:0] A_RLD = 8'h70;
  localparam logic [7:0] A_CTL = 8'h72;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [15:0] bus_wdata = 16'h0000;
  logic [15:0] bus_rdata;
  logic        nmi, sysrst;
  int          nvec = 0;
  int          nfail = 0;

  always #2.5 clk = ~clk;

  wdt_nmi_top #(.TICK_DIV(TDIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pretimeout_nmi(nmi), .sys_reset(sysrst)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called just after a falling edge; returns just after the next falling edge
  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd(A_RLD, v); chk("R1/R10 default count", v, 32'(30 * 1000 / 128));
    rd(A_CTL, v); chk("R1 ctrl after reset", v, 0);
    chk("R1 nmi low", nmi, 0);
    chk("R1 reset low", sysrst, 0);
    chk("R10 600 s units", wdt_pkg::secs_to_units(600), 4687);
    wr(A_CTL, 16'h0001);
    rd(A_RLD, v); chk("R10 start from default", v, 234);
    wr(A_CTL, 16'h0000);
  endtask

  task automatic t_regs;
    logic [15:0] v;
    wr(A_RLD, 16'h1234);
    rd(A_RLD, v); chk("R2 reload readback", v, 16'h1234);
    step(10);
    rd(A_RLD, v); chk("R2 idle count held", v, 16'h1234);
    wr(A_CTL, 16'hAB84);
    rd(A_CTL, v); chk("R3 upper byte dropped", v, 16'h0084);
    rd(A_RLD, v); chk("R3 no load without bit0", v, 16'h1234);
  endtask

  task automatic t_count_expire;
    logic [15:0] v;
    wr(A_RLD, 16'd80);
    wr(A_CTL, 16'h0085);                      // load edge E
    rd(A_CTL, v); chk("R3 ctrl running", v, 16'h0085);
    rd(A_RLD, v); chk("R3 start loads", v, 80);
    step(3); rd(A_RLD, v); chk("R4 before first tick", v, 80);
    step(1); rd(A_RLD, v); chk("R4 first tick", v, 79);
    step(31); rd(A_RLD, v); chk("R4 E+35 count", v, 72);
    chk("R6 nmi not yet", nmi, 0);
    step(1); chk("R6 nmi at threshold", nmi, 1);
    step(283); rd(A_RLD, v); chk("R7 last unit", v, 1);
    chk("R7 reset not yet", sysrst, 0);
    step(1); chk("R7 reset asserted", sysrst, 1);
    chk("R6 nmi during reset", nmi, 1);
    step(3); chk("R7 reset held one tick", sysrst, 1);
    step(1); chk("R7 reset ended", sysrst, 0);
    rd(A_CTL, v); chk("R7 run bit cleared", v, 16'h0084);
    chk("R7 nmi dropped", nmi, 0);
    step(8); chk("R7 stays stopped", sysrst, 0);
  endtask

  task automatic t_ping;
    logic [15:0] v;
    wr(A_RLD, 16'd100);
    wr(A_CTL, 16'h0085);
    step(10); rd(A_RLD, v); chk("R4 two ticks", v, 98);
    wr(A_RLD, 16'd90);
    rd(A_RLD, v); chk("R5 ping value", v, 90);
    step(3); rd(A_RLD, v); chk("R5 phase restarted", v, 90);
    step(1); rd(A_RLD, v); chk("R5 tick after ping", v, 89);
    wr(A_RLD, 16'd50); chk("R6 immediate nmi", nmi, 1);
    wr(A_RLD, 16'd200); chk("R5 ping drops nmi", nmi, 0);
  endtask

  task automatic t_disable;
    logic [15:0] v;
    wr(A_CTL, 16'h0085);                      // one edge after the 200 load
    rd(A_RLD, v); chk("R8 rewrite no reload", v, 200);
    step(3); rd(A_RLD, v); chk("R8 phase kept", v, 199);
    wr(A_RLD, 16'd40); chk("R6 nmi on low load", nmi, 1);
    wr(A_CTL, 16'h0084); chk("R8 nmi off when stopped", nmi, 0);
    step(20); rd(A_RLD, v); chk("R8 count held", v, 40);
    chk("R8 no reset", sysrst, 0);
  endtask

  task automatic t_zero;
    logic [15:0] v;
    wr(A_CTL, 16'h0085);
    wr(A_RLD, 16'd0);
    chk("R9 nmi on zero", nmi, 1);
    step(3); chk("R9 no reset yet", sysrst, 0);
    step(1); chk("R9 expires first tick", sysrst, 1);
    step(4); chk("R9 pulse over", sysrst, 0);
    rd(A_CTL, v); chk("R9 stopped", v, 16'h0084);
  endtask

  initial begin
    #(5.0 * 150000);
    nfail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset;
    t_regs;
    t_count_expire;
    t_ping;
    t_disable;
    t_zero;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule